// File: doc/BRIEF.md
# Set-Associative Cache Tag Controller

This block keeps the tag, valid and dirty state for a 32 KB data cache. The cache has four ways and 256 sets, and each line is 32 bytes (eight 32-bit words). A client presents a 32-bit address with a read/write flag. One cycle later the block reports whether the access hits and in which way. On a miss it also reports which way should receive the new line, and whether that line holds modified data that must be written back first. It also returns the old tag, so the write-back address can be formed.

The block does not move any data. The client runs the linefill itself. When the fill is done, the client tells the block which address and way were filled, and the block installs the new tag as a clean, valid line.

Victim choice follows four rules:
- A way marked in the lockdown mask is never chosen.
- A free (invalid) line is taken before any line is replaced.
- Among valid lines, either a rotating pointer or a free-running pseudo-random source picks the way.
- A global invalidate sweeps all sets, one per cycle. Lookups are refused while the sweep runs.

Top module: `cache_tag_ctrl`

## Requirements
- R1: The address is split as byte/word offset [4:0], set index [12:5] and tag [31:13]. A lookup hits only if the set index and the tag both match a filled line, whatever the offset bits are.
- R2: A request accepted while not busy gives `rsp_valid`=1 on the clock edge that follows, with results based on the tag state as it stood when the request was presented.
- R3: After reset, and for any line that has not been filled, a lookup never hits.
- R4: A write that hits marks that line modified. When that line is later chosen for replacement, `rsp_victim_dirty`=1 and `rsp_victim_tag` holds its tag.
- R5: A fill installs the tag from `fill_addr` into way `fill_way` of the addressed set as valid and clean, and clears any earlier modified mark on that line.
- R6: On a miss, if the set has an invalid way that is not locked, the lowest-numbered such way is the victim, whatever policy is selected.
- R7: With `policy_rand`=0, a replacement picks the first unlocked way found by counting upward (wrapping) from a pointer. The pointer is 0 after reset and moves to victim+1 only when a valid line is replaced.
- R8: With `policy_rand`=1, a replacement picks the first unlocked way counting upward from a 16-bit LFSR value that steps every cycle. With a single unlocked way, that way is always chosen.
- R9: A way whose bit is 1 in `lock_mask` (bit n is way n) is never reported as victim. This holds even when that way is invalid.
- R10: A miss with all four ways locked sets `rsp_no_alloc`=1 and reports victim way 0, clean, tag 0. A hit with all ways locked still reports the hit, with `rsp_no_alloc`=0.
- R11: A pulse on `inv_start` raises `busy` for exactly 256 cycles. Requests made while `busy` get no response. Afterwards every line is invalid and clean.
- R12: On a hit, `rsp_hit_way` names the matching way and `rsp_victim_dirty`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Lookup request strobe |
| req_addr | input | 32 | Lookup address |
| req_write | input | 1 | 1 = store access (sets dirty on hit) |
| lock_mask | input | 4 | Per-way lockdown, bit n locks way n |
| policy_rand | input | 1 | 0 = round-robin, 1 = pseudo-random replacement |
| inv_start | input | 1 | Start global invalidate sweep |
| fill_valid | input | 1 | Linefill completed strobe |
| fill_addr | input | 32 | Address of the filled line |
| fill_way | input | 2 | Way that received the fill |
| busy | output | 1 | Invalidate sweep in progress |
| rsp_valid | output | 1 | Lookup result valid |
| rsp_hit | output | 1 | Lookup hit |
| rsp_hit_way | output | 2 | Way that hit |
| rsp_victim_way | output | 2 | Way chosen for allocation on a miss |
| rsp_victim_dirty | output | 1 | Victim holds modified data |
| rsp_victim_tag | output | 19 | Tag currently held by the victim |
| rsp_no_alloc | output | 1 | Miss with every way locked |

## Verification
The bench first fills one set completely. It then walks the rotating pointer through locked ways, and drops in misses on an empty set to confirm the pointer holds still when only a free line is allocated. A design that advanced the pointer on every miss, or stopped on a locked way, would report the wrong way on the following miss.

A modified line is evicted to show that the dirty flag and the old tag come out. The same way is then refilled and evicted again to confirm the refill left it clean. A design that kept stale dirty bits would ask for a spurious write-back.

Full lockdown, including on an empty set, must give the no-allocate flag rather than a locked way. The invalidate sweep is timed to the cycle, a lookup made during it must be dropped, and every line must miss after it.

// File: rtl/cache_tag_pkg.sv
// Shared definitions for the cache tag controller.
package cache_tag_pkg;
    // Replacement policy encoding driven by policy_rand.
    typedef enum logic {
        POL_ROTATE = 1'b0,
        POL_RANDOM = 1'b1
    } repl_pol_e;

    localparam logic [15:0] LFSR_SEED = 16'hACE1;
endpackage

// File: rtl/ctag_way_store.sv
// One way of tag state: a tag array plus per-line valid and dirty bits.
// Assumes: the clear port has priority over fill and dirty-set; tags are not
// reset (valid bits guard them). Reads are combinational by index.
module ctag_way_store #(
    parameter int SETS  = 256,
    parameter int TAG_W = 19,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [TAG_W-1:0] rd_tag,
    output logic             rd_valid,
    output logic             rd_dirty,
    input  logic             fill_en,
    input  logic [IDX_W-1:0] fill_idx,
    input  logic [TAG_W-1:0] fill_tag,
    input  logic             dirty_en,
    input  logic [IDX_W-1:0] dirty_idx,
    input  logic             clr_en,
    input  logic [IDX_W-1:0] clr_idx
);
    logic [TAG_W-1:0] tag_mem [SETS];
    logic [SETS-1:0]  vld_q;
    logic [SETS-1:0]  drt_q;

    // Tag array write on fill.
    always_ff @(posedge clk) begin
        if (fill_en) begin
            tag_mem[fill_idx] <= fill_tag;
        end
    end

    // Valid/dirty update: clear sweep, then fill, then write-hit marking.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_q <= '0;
            drt_q <= '0;
        end else if (clr_en) begin
            vld_q[clr_idx] <= 1'b0;
            drt_q[clr_idx] <= 1'b0;
        end else begin
            if (dirty_en) begin
                drt_q[dirty_idx] <= 1'b1;
            end
            if (fill_en) begin
                vld_q[fill_idx] <= 1'b1;
                drt_q[fill_idx] <= 1'b0;
            end
        end
    end

    // Combinational read port.
    always_comb begin
        rd_tag   = tag_mem[rd_idx];
        rd_valid = vld_q[rd_idx];
        rd_dirty = drt_q[rd_idx];
    end
endmodule

// File: rtl/ctag_victim_sel.sv
// Victim choice for one set. Assumes WAYS is a power of two so the way
// counter wraps naturally. Locked ways are never returned; a free unlocked
// way wins over the policy; none_ok flags a fully locked set.
module ctag_victim_sel
    import cache_tag_pkg::*;
#(
    parameter int WAYS = 4,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic [WAYS-1:0]  valid_vec,
    input  logic [WAYS-1:0]  lock_vec,
    input  repl_pol_e        policy,
    input  logic [WAY_W-1:0] rot_ptr,
    input  logic [WAY_W-1:0] rnd_val,
    output logic [WAY_W-1:0] victim,
    output logic             replace,
    output logic             none_ok
);
    logic [WAYS-1:0]  free_vec;
    logic [WAY_W-1:0] free_way;
    logic             free_hit;
    logic [WAY_W-1:0] start;
    logic [WAY_W-1:0] cand;
    logic [WAY_W-1:0] pol_way;
    logic             pol_hit;

    // Lowest-numbered invalid, unlocked way.
    always_comb begin
        free_vec = ~valid_vec & ~lock_vec;
        free_way = '0;
        free_hit = 1'b0;
        for (int i = WAYS - 1; i >= 0; i--) begin
            if (free_vec[i]) begin
                free_way = WAY_W'(i);
                free_hit = 1'b1;
            end
        end
    end

    // First unlocked way counting upward from the policy's start point.
    always_comb begin
        start   = (policy == POL_RANDOM) ? rnd_val : rot_ptr;
        pol_way = '0;
        pol_hit = 1'b0;
        cand    = '0;
        for (int k = 0; k < WAYS; k++) begin
            cand = start + WAY_W'(k);
            if (!pol_hit && !lock_vec[cand]) begin
                pol_way = cand;
                pol_hit = 1'b1;
            end
        end
    end

    // Final decision.
    always_comb begin
        none_ok = &lock_vec;
        replace = !free_hit && pol_hit;
        if (free_hit) begin
            victim = free_way;
        end else if (pol_hit) begin
            victim = pol_way;
        end else begin
            victim = '0;
        end
    end
endmodule

// File: rtl/ctag_lfsr.sv
// Free-running Fibonacci LFSR (taps 16,14,13,11), stepped every cycle.
// Assumes the seed is non-zero.
module ctag_lfsr #(
    parameter int          W    = 16,
    parameter logic [W-1:0] SEED = 16'hACE1
) (
    input  logic         clk,
    input  logic         rst_n,
    output logic [W-1:0] state
);
    // Shift one step per clock.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= SEED;
        end else begin
            state <= {state[W-2:0], state[W-1] ^ state[W-3] ^ state[W-4] ^ state[W-6]};
        end
    end
endmodule

// File: rtl/ctag_inv_seq.sv
// Global invalidate sequencer: on start, walks every set index once,
// one per cycle, holding busy for exactly SETS cycles. Starts while busy
// are ignored.
module ctag_inv_seq #(
    parameter int SETS = 256,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    output logic             busy,
    output logic [IDX_W-1:0] idx
);
    // Sweep counter and busy flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy <= 1'b0;
            idx  <= '0;
        end else if (busy) begin
            idx <= idx + 1'b1;
            if (idx == IDX_W'(SETS - 1)) begin
                busy <= 1'b0;
            end
        end else if (start) begin
            busy <= 1'b1;
            idx  <= '0;
        end
    end
endmodule

// File: rtl/cache_tag_ctrl.sv
// Tag controller for a set-associative data cache. It looks up an address
// against every way of the indexed set, registers the hit/victim decision
// one cycle later, marks lines dirty on write hits, installs tags on fill
// completion and runs a global invalidate sweep.
// Assumes: WAYS and SETS are powers of two; fills arriving while busy are
// dropped; a lookup sees the state before any same-cycle fill.
module cache_tag_ctrl
    import cache_tag_pkg::*;
#(
    parameter int ADDR_W     = 32,
    parameter int LINE_BYTES = 32,
    parameter int SETS       = 256,
    parameter int WAYS       = 4,
    localparam int OFF_W = $clog2(LINE_BYTES),
    localparam int IDX_W = $clog2(SETS),
    localparam int TAG_W = ADDR_W - OFF_W - IDX_W,
    localparam int WAY_W = $clog2(WAYS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [WAYS-1:0]   lock_mask,
    input  logic              policy_rand,
    input  logic              inv_start,
    input  logic              fill_valid,
    input  logic [ADDR_W-1:0] fill_addr,
    input  logic [WAY_W-1:0]  fill_way,
    output logic              busy,
    output logic              rsp_valid,
    output logic              rsp_hit,
    output logic [WAY_W-1:0]  rsp_hit_way,
    output logic [WAY_W-1:0]  rsp_victim_way,
    output logic              rsp_victim_dirty,
    output logic [TAG_W-1:0]  rsp_victim_tag,
    output logic              rsp_no_alloc
);
    logic [IDX_W-1:0] req_idx, fill_idx, clr_idx;
    logic [TAG_W-1:0] req_tag, fill_tag;
    logic             req_fire;
    logic [TAG_W-1:0] way_tag   [WAYS];
    logic [WAYS-1:0]  way_valid, way_dirty, hit_vec;
    logic             hit_any;
    logic [WAY_W-1:0] hit_way;
    logic [WAY_W-1:0] vic_way, rot_ptr;
    logic             vic_replace, all_locked;
    logic [15:0]      lfsr_q;
    repl_pol_e        policy;

    assign req_idx  = req_addr[OFF_W +: IDX_W];
    assign req_tag  = req_addr[OFF_W + IDX_W +: TAG_W];
    assign fill_idx = fill_addr[OFF_W +: IDX_W];
    assign fill_tag = fill_addr[OFF_W + IDX_W +: TAG_W];
    assign req_fire = req_valid && !busy;
    assign policy   = repl_pol_e'(policy_rand);

    ctag_inv_seq #(.SETS(SETS)) i_inv (
        .clk   (clk),
        .rst_n (rst_n),
        .start (inv_start),
        .busy  (busy),
        .idx   (clr_idx)
    );

    ctag_lfsr #(.W(16), .SEED(LFSR_SEED)) i_lfsr (
        .clk   (clk),
        .rst_n (rst_n),
        .state (lfsr_q)
    );

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        ctag_way_store #(.SETS(SETS), .TAG_W(TAG_W)) i_store (
            .clk       (clk),
            .rst_n     (rst_n),
            .rd_idx    (req_idx),
            .rd_tag    (way_tag[w]),
            .rd_valid  (way_valid[w]),
            .rd_dirty  (way_dirty[w]),
            .fill_en   (fill_valid && !busy && (fill_way == WAY_W'(w))),
            .fill_idx  (fill_idx),
            .fill_tag  (fill_tag),
            .dirty_en  (req_fire && req_write && hit_vec[w]),
            .dirty_idx (req_idx),
            .clr_en    (busy),
            .clr_idx   (clr_idx)
        );
        assign hit_vec[w] = way_valid[w] && (way_tag[w] == req_tag);
    end

    // Encode the matching way.
    always_comb begin
        hit_any = |hit_vec;
        hit_way = '0;
        for (int i = 0; i < WAYS; i++) begin
            if (hit_vec[i]) begin
                hit_way = WAY_W'(i);
            end
        end
    end

    ctag_victim_sel #(.WAYS(WAYS)) i_vsel (
        .valid_vec (way_valid),
        .lock_vec  (lock_mask),
        .policy    (policy),
        .rot_ptr   (rot_ptr),
        .rnd_val   (lfsr_q[WAY_W-1:0]),
        .victim    (vic_way),
        .replace   (vic_replace),
        .none_ok   (all_locked)
    );

    // Rotating pointer: moves past the victim only on a real replacement.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rot_ptr <= '0;
        end else if (req_fire && !hit_any && vic_replace && policy == POL_ROTATE) begin
            rot_ptr <= vic_way + 1'b1;
        end
    end

    // Registered lookup response.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid        <= 1'b0;
            rsp_hit          <= 1'b0;
            rsp_hit_way      <= '0;
            rsp_victim_way   <= '0;
            rsp_victim_dirty <= 1'b0;
            rsp_victim_tag   <= '0;
            rsp_no_alloc     <= 1'b0;
        end else begin
            rsp_valid        <= req_fire;
            rsp_hit          <= req_fire && hit_any;
            rsp_hit_way      <= hit_any ? hit_way : '0;
            rsp_victim_way   <= '0;
            rsp_victim_dirty <= 1'b0;
            rsp_victim_tag   <= '0;
            rsp_no_alloc     <= 1'b0;
            if (req_fire && !hit_any) begin
                if (all_locked) begin
                    rsp_no_alloc <= 1'b1;
                end else begin
                    rsp_victim_way   <= vic_way;
                    rsp_victim_dirty <= way_valid[vic_way] && way_dirty[vic_way];
                    rsp_victim_tag   <= way_valid[vic_way] ? way_tag[vic_way] : '0;
                end
            end
        end
    end
endmodule

// File: rtl/ctag_checker.sv
// Property checker for cache_tag_ctrl, attached by bind below.
module ctag_checker #(
    parameter int SETS  = 256,
    parameter int WAYS  = 4,
    parameter int WAY_W = 2
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic [WAYS-1:0]  lock_mask,
    input logic             busy,
    input logic             rsp_valid,
    input logic             rsp_hit,
    input logic [WAY_W-1:0] rsp_victim_way,
    input logic             rsp_victim_dirty,
    input logic             rsp_no_alloc
);
    localparam int CNT_W = $clog2(SETS) + 2;
    logic [WAYS-1:0]  lock_d;
    logic [CNT_W-1:0] busy_cnt;

    // Lock mask as seen by the request that produced the current response.
    always_ff @(posedge clk) begin
        if (!rst_n) lock_d <= '0;
        else        lock_d <= lock_mask;
    end

    // Length of the current busy run.
    always_ff @(posedge clk) begin
        if (!rst_n)    busy_cnt <= '0;
        else if (busy) busy_cnt <= busy_cnt + 1'b1;
        else           busy_cnt <= '0;
    end

    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !busy) |=> rsp_valid);                                  // R2
    AST_BUSY_DROPS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> !rsp_valid);                                                 // R11
    AST_SWEEP_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && busy_cnt != 0) |-> (busy_cnt == CNT_W'(SETS)));             // R11
    AST_VICTIM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && !rsp_hit && !rsp_no_alloc) |-> !lock_d[rsp_victim_way]); // R9
    AST_NOALLOC_ALL_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_no_alloc) |-> (&lock_d && !rsp_hit));               // R10
    AST_HIT_CLEAN: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_hit |-> (!rsp_victim_dirty && !rsp_no_alloc));                    // R12
endmodule

bind cache_tag_ctrl ctag_checker #(.SETS(SETS), .WAYS(WAYS), .WAY_W(WAY_W)) i_ctag_checker (
    .clk              (clk),
    .rst_n            (rst_n),
    .req_valid        (req_valid),
    .lock_mask        (lock_mask),
    .busy             (busy),
    .rsp_valid        (rsp_valid),
    .rsp_hit          (rsp_hit),
    .rsp_victim_way   (rsp_victim_way),
    .rsp_victim_dirty (rsp_victim_dirty),
    .rsp_no_alloc     (rsp_no_alloc)
);

// File: tb/test_cache_tag_ctrl.sv
`timescale 1ns/1ps
module test_cache_tag_ctrl;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [3:0]  lock_mask = '0;
    logic        policy_rand = 1'b0;
    logic        inv_start = 1'b0;
    logic        fill_valid = 1'b0;
    logic [31:0] fill_addr = '0;
    logic [1:0]  fill_way = '0;
    logic        busy, rsp_valid, rsp_hit, rsp_victim_dirty, rsp_no_alloc;
    logic [1:0]  rsp_hit_way, rsp_victim_way;
    logic [18:0] rsp_victim_tag;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cache_tag_ctrl i_cache_tag_ctrl (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr(req_addr),
        .req_write(req_write), .lock_mask(lock_mask), .policy_rand(policy_rand),
        .inv_start(inv_start), .fill_valid(fill_valid), .fill_addr(fill_addr),
        .fill_way(fill_way), .busy(busy), .rsp_valid(rsp_valid), .rsp_hit(rsp_hit),
        .rsp_hit_way(rsp_hit_way), .rsp_victim_way(rsp_victim_way),
        .rsp_victim_dirty(rsp_victim_dirty), .rsp_victim_tag(rsp_victim_tag),
        .rsp_no_alloc(rsp_no_alloc)
    );

    function automatic logic [31:0] mk(input logic [18:0] t, input logic [7:0] s, input logic [4:0] o);
        return {t, s, o};
    endfunction

    task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", rq, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // Fill completion for one line.
    task automatic do_fill(input logic [31:0] a, input logic [1:0] w);
        @(negedge clk);
        fill_valid = 1'b1; fill_addr = a; fill_way = w;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // One lookup; results sampled at the negedge after the registering edge.
    task automatic look(input logic [31:0] a, input logic wr);
        @(negedge clk);
        req_valid = 1'b1; req_addr = a; req_write = wr;
        @(negedge clk);
        req_valid = 1'b0; req_write = 1'b0;
    endtask

    task automatic expect_miss(input string rq, input logic [1:0] vw, input logic vd);
        chk({rq, " valid"}, rsp_valid, 1);
        chk({rq, " hit"}, rsp_hit, 0);
        chk({rq, " no_alloc"}, rsp_no_alloc, 0);
        chk({rq, " victim"}, rsp_victim_way, vw);
        chk({rq, " dirty"}, rsp_victim_dirty, vd);
    endtask

    task automatic t_reset();
        chk("R3 reset rsp_valid", rsp_valid, 0);
        chk("R11 reset busy", busy, 0);
        look(mk(19'h1, 8'd5, 5'd0), 0);
        expect_miss("R3/R6 empty set", 2'd0, 0);
    endtask

    task automatic t_hit_split();
        do_fill(mk(19'h0A, 8'd5, 5'd0), 2'd0);
        look(mk(19'h0A, 8'd5, 5'd28), 0);
        chk("R1 hit other offset", rsp_hit, 1);
        chk("R12 hit way", rsp_hit_way, 0);
        chk("R2 rsp_valid", rsp_valid, 1);
        look(mk(19'h0A, 8'd6, 5'd0), 0);
        chk("R1 other set misses", rsp_hit, 0);
        look(mk(19'h0B, 8'd5, 5'd0), 0);
        expect_miss("R6 next free way", 2'd1, 0);
        lock_mask = 4'b0010;
        look(mk(19'h0B, 8'd5, 5'd0), 0);
        expect_miss("R9 skip locked free way", 2'd2, 0);
        lock_mask = 4'b0000;
    endtask

    task automatic t_rotate();
        do_fill(mk(19'h0B, 8'd5, 0), 2'd1);
        do_fill(mk(19'h0C, 8'd5, 0), 2'd2);
        do_fill(mk(19'h0D, 8'd5, 0), 2'd3);
        look(mk(19'h0A, 8'd5, 5'd4), 1);
        chk("R12 write hit", rsp_hit, 1);
        chk("R12 hit dirty 0", rsp_victim_dirty, 0);
        look(mk(19'h0E, 8'd5, 0), 0);
        expect_miss("R4/R7 evict modified way0", 2'd0, 1);
        chk("R4 victim tag", rsp_victim_tag, 19'h0A);
        do_fill(mk(19'h0E, 8'd5, 0), 2'd0);
        look(mk(19'h0E, 8'd5, 0), 0);
        chk("R5 refilled hit", rsp_hit, 1);
        look(mk(19'h0F, 8'd5, 0), 0);
        expect_miss("R7 pointer 1", 2'd1, 0);
        lock_mask = 4'b0100;
        look(mk(19'h0F, 8'd5, 0), 0);
        expect_miss("R7 skip locked 2", 2'd3, 0);
        lock_mask = 4'b0001;
        look(mk(19'h0F, 8'd5, 0), 0);
        expect_miss("R7 wrap skip locked 0", 2'd1, 0);
        lock_mask = 4'b0000;
        look(mk(19'h0F, 8'd9, 0), 0);
        expect_miss("R6 free alloc other set", 2'd0, 0);
        look(mk(19'h0F, 8'd5, 0), 0);
        expect_miss("R7 pointer held on free alloc", 2'd2, 0);
        lock_mask = 4'b0111;
        look(mk(19'h0F, 8'd5, 0), 0);
        expect_miss("R7 pointer 3", 2'd3, 0);
        lock_mask = 4'b0000;
        look(mk(19'h0F, 8'd5, 0), 0);
        expect_miss("R5 refilled way clean", 2'd0, 0);
        chk("R5 victim tag", rsp_victim_tag, 19'h0E);
    endtask

    task automatic t_all_locked();
        lock_mask = 4'b1111;
        look(mk(19'h0F, 8'd5, 0), 0);
        chk("R10 no_alloc", rsp_no_alloc, 1);
        chk("R10 hit", rsp_hit, 0);
        chk("R10 victim way", rsp_victim_way, 0);
        chk("R10 victim tag", rsp_victim_tag, 0);
        look(mk(19'h0F, 8'd7, 0), 0);
        chk("R9 locked free ways", rsp_no_alloc, 1);
        look(mk(19'h0C, 8'd5, 0), 0);
        chk("R10 hit still reported", rsp_hit, 1);
        chk("R10 hit way", rsp_hit_way, 2);
        chk("R10 hit no_alloc", rsp_no_alloc, 0);
        lock_mask = 4'b0000;
    endtask

    task automatic t_random();
        logic [3:0] seen = '0;
        int bad = 0;
        policy_rand = 1'b1;
        lock_mask = 4'b1011;
        for (int i = 0; i < 8; i++) begin
            look(mk(19'h10, 8'd5, 0), 0);
            if (rsp_victim_way !== 2'd2) bad++;
        end
        chk("R8 single unlocked way", bad, 0);
        lock_mask = 4'b1000;
        bad = 0;
        for (int i = 0; i < 40; i++) begin
            look(mk(19'h10, 8'd5, 0), 0);
            if (rsp_victim_way === 2'd3 || rsp_no_alloc) bad++;
            seen[rsp_victim_way] = 1'b1;
        end
        chk("R8/R9 random never locked", bad, 0);
        chk("R8 random spreads", ($countones(seen) >= 2), 1);
        lock_mask = 4'b0000;
        policy_rand = 1'b0;
    endtask

    task automatic t_invalidate();
        int n = 0;
        @(negedge clk);
        inv_start = 1'b1;
        @(negedge clk);
        inv_start = 1'b0;
        req_valid = 1'b1; req_addr = mk(19'h0C, 8'd5, 0);
        @(negedge clk);
        req_valid = 1'b0;
        chk("R11 request dropped while busy", rsp_valid, 0);
        n = 2;
        while (busy && n < 400) begin
            @(negedge clk);
            if (busy) n++;
        end
        chk("R11 busy cycles", n, 256);
        look(mk(19'h0C, 8'd5, 0), 0);
        expect_miss("R11 swept set misses", 2'd0, 0);
        look(mk(19'h0F, 8'd9, 0), 0);
        expect_miss("R11 other set misses", 2'd0, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_hit_split();
        t_rotate();
        t_all_locked();
        t_random();
        t_invalidate();
        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=timeout expected=finish");
            summary();
            $finish;
        end
    end
endmodule